// File: doc/BRIEF.md
# Runtime-Configurable Serial Transmit Framer

This block turns one data byte into an asynchronous serial frame on a line that rests high. A request strobe starts the frame. The block then sends the parts of the frame in this order:

- a low start bit;
- five to eight data bits, least significant bit first;
- an optional parity bit;
- a high stop period of one, one and a half or two bit times.

Time is measured in ticks of a 16x oversampling baud strobe that comes from outside the block. Each bit lasts sixteen ticks, so the half-bit stop case lasts twenty-four ticks.

The frame format comes in on level inputs: word length, parity on/off, parity sense and the long-stop choice. Together with the byte, these inputs are captured in the cycle the request is accepted. The caller may change them while a frame is in flight. A busy flag stays high for the whole frame, and requests that arrive while it is high are dropped.

Top module: `serial_tx_framer`

## Requirements
- R1: Out of reset and whenever no frame is in progress, `txd` is 1 and `busy` is 0.
- R2: A `tx_start` seen while `busy` is 0 is accepted. In the next cycle `busy` is 1 and `txd` is 0, and the start bit lasts 16 baud ticks. A baud tick in the acceptance cycle itself is not counted.
- R3: `len_sel` values 0, 1, 2 and 3 send 5, 6, 7 and 8 data bits. Data goes out as `tx_data[0]` first, and each data bit lasts 16 ticks. Unused upper bits of the byte are never sent.
- R4: With `par_en` at 0, no parity bit is sent and `par_even` has no effect on the line.
- R5: With `par_en` at 1, one parity bit of 16 ticks follows the data bits. With `par_even` at 1, the total number of ones in data plus parity is even; with `par_even` at 0, it is odd.
- R6: With `stop_long` at 0, the stop period is high for 16 ticks.
- R7: With `stop_long` at 1 and a word length of 6, 7 or 8 bits, the stop period is high for 32 ticks.
- R8: With `stop_long` at 1 and a 5-bit word, the stop period is high for 24 ticks.
- R9: Byte and format inputs are captured only at acceptance. Changing them during a frame does not alter that frame.
- R10: `tx_start` while `busy` is 1 is ignored. This includes the cycle in which the last stop tick is consumed. `busy` falls in the cycle after that last stop tick.
- R11: Bit timing advances only on baud ticks, and the line level holds steady between ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_data | input | 8 | Byte to send |
| tx_start | input | 1 | Request strobe, accepted only when idle |
| baud_tick | input | 1 | 16x oversampling tick, one cycle wide |
| len_sel | input | 2 | Word length select (5 + value data bits) |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| stop_long | input | 1 | 0 = one stop bit, 1 = two (1.5 for 5-bit words) |
| txd | output | 1 | Serial line, high when idle |
| busy | output | 1 | Frame in progress |

## Verification
Two events can fall on the same clock edge.

First, a request can coincide with a baud tick. The bench provokes this by aligning its strobe with a tick. The monitor then counts start-bit ticks only while `busy` is high, so one extra tick shows up as a wrong frame length.

Second, a request can coincide with the final stop tick. The bench holds `tx_start` high through the whole frame, including the edge that ends it. It is judged correct when no second frame appears and the line stays idle for several cycles afterwards.

// File: rtl/txf_pkg.sv
// Shared types for the serial transmit framer.
// Assumes nothing beyond a standard SystemVerilog package scope.
package txf_pkg;

    // Frame phases, in the order they go out on the line.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } phase_t;

    // Format controls captured at frame acceptance.
    typedef struct packed {
        logic [1:0] len_sel;
        logic       par_en;
        logic       par_even;
        logic       stop_long;
    } frame_fmt_t;

endpackage

// File: rtl/txf_frame_capture.sv
// Frame capture: registers the byte and the format when a frame is accepted.
// From the held copy it derives the index of the last data bit, the parity
// bit and the length of the stop period in ticks.
// Assumes load_i pulses only while the sequencer is idle, and that
// TICKS_PER_BIT is even so that a half bit is a whole number of ticks.
module txf_frame_capture
    import txf_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16,
    parameter int CNT_W         = 6,
    parameter int IDX_W         = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] data_i,
    input  frame_fmt_t        fmt_i,
    output logic [DATA_W-1:0] data_o,
    output logic [IDX_W-1:0]  last_idx_o,
    output logic              par_en_o,
    output logic              par_bit_o,
    output logic [CNT_W-1:0]  stop_ticks_o
);

    localparam int MIN_LAST = DATA_W - 4;
    localparam int HALF_BIT = TICKS_PER_BIT / 2;

    logic [DATA_W-1:0] data_q;
    frame_fmt_t        fmt_q;
    logic [DATA_W-1:0] used_mask;
    logic              ones_odd;

    // Capture the byte and format on acceptance; hold them for the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            fmt_q  <= '0;
        end else if (load_i) begin
            data_q <= data_i;
            fmt_q  <= fmt_i;
        end
    end

    // Index of the final data bit: word length minus one.
    always_comb begin
        last_idx_o = IDX_W'(MIN_LAST) + IDX_W'(fmt_q.len_sel);
    end

    // Mask of the data bits that are actually sent.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            used_mask[i] = (i <= int'(last_idx_o));
        end
    end

    // Parity over the sent bits only; the sense follows the even select.
    always_comb begin
        ones_odd  = ^(data_q & used_mask);
        par_bit_o = fmt_q.par_even ? ones_odd : ~ones_odd;
    end

    // Stop period length in ticks: one bit, two bits, or 1.5 bits for the shortest word.
    always_comb begin
        if (!fmt_q.stop_long) begin
            stop_ticks_o = CNT_W'(TICKS_PER_BIT);
        end else if (fmt_q.len_sel == 2'b00) begin
            stop_ticks_o = CNT_W'(TICKS_PER_BIT + HALF_BIT);
        end else begin
            stop_ticks_o = CNT_W'(2 * TICKS_PER_BIT);
        end
    end

    assign data_o   = data_q;
    assign par_en_o = fmt_q.par_en;

    // R9: the held copy cannot move while a frame is on the line.
    p_fmt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !load_i) |=> ($stable(fmt_q) && $stable(data_q)));

endmodule

// File: rtl/txf_tick_timer.sv
// Tick timer: counts baud ticks inside the current phase and flags the tick
// that completes the phase.
// Assumes limit_i is at least 1 and stays constant within a phase; the
// counter clears whenever it is not running or a phase completes.
module txf_tick_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_q;

    // The phase completes on the tick that brings the count to the limit.
    always_comb begin
        done_o = run_i && tick_i && (cnt_q == limit_i - CNT_W'(1));
    end

    // Count ticks while running; clear when idle and at each phase boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || done_o) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R11: the count stays within the current phase length.
    p_cnt_below_limit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < limit_i));

    // R11: without a tick, the position inside the phase does not move.
    p_hold_between_ticks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/txf_phase_fsm.sv
// Phase sequencer: walks start, data, optional parity and stop phases, one
// step per completed phase, and drives the line level for each phase.
// Assumes done_i is a single-cycle flag from the tick timer, and that the
// capture block presents a stable byte and format while busy.
module txf_phase_fsm
    import txf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              done_i,
    input  logic [IDX_W-1:0]  last_idx_i,
    input  logic              par_en_i,
    input  logic              par_bit_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              load_o,
    output logic              busy_o,
    output logic              is_stop_o,
    output logic              txd_o
);

    phase_t           phase_q;
    phase_t           phase_d;
    logic [IDX_W-1:0] idx_q;

    // Accept a request only from idle.
    always_comb begin
        load_o = (phase_q == PH_IDLE) && start_i;
    end

    // Choose the next phase from the current one and the completion flag.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:   if (load_o) phase_d = PH_START;
            PH_START:  if (done_i) phase_d = PH_DATA;
            PH_DATA:   if (done_i && idx_q == last_idx_i)
                           phase_d = par_en_i ? PH_PARITY : PH_STOP;
            PH_PARITY: if (done_i) phase_d = PH_STOP;
            PH_STOP:   if (done_i) phase_d = PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    // Register the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Step the data bit index at each completed data bit; restart it per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (phase_q != PH_DATA) begin
            idx_q <= '0;
        end else if (done_i) begin
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    // Line level per phase: low start, data bit, parity bit, high otherwise.
    always_comb begin
        unique case (phase_q)
            PH_START:  txd_o = 1'b0;
            PH_DATA:   txd_o = data_i[idx_q];
            PH_PARITY: txd_o = par_bit_i;
            default:   txd_o = 1'b1;
        endcase
    end

    assign busy_o    = (phase_q != PH_IDLE);
    assign is_stop_o = (phase_q == PH_STOP);

    // R1: the line rests high whenever no frame is running.
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> txd_o);

    // R2: every frame opens with a low start bit.
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !txd_o);

    // R10: the frame ends in the cycle after the last stop tick.
    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_stop_o && done_i) |=> !busy_o);

    // R10: a frame in flight is never cut short, whatever tx_start does.
    p_busy_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !(is_stop_o && done_i)) |=> busy_o);

endmodule

// File: rtl/serial_tx_framer.sv
// Serial transmit framer top: joins frame capture, tick timer and phase
// sequencer. The tick timer's limit is one bit time, except in the stop
// phase, where it is the captured stop length.
// Assumes baud_tick is one cycle wide at 16x the bit rate, and that the
// inputs are synchronous to clk.
module serial_tx_framer
    import txf_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] tx_data,
    input  logic       tx_start,
    input  logic       baud_tick,
    input  logic [1:0] len_sel,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       stop_long,
    output logic       txd,
    output logic       busy
);

    localparam int DATA_W = 8;
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int CNT_W  = $clog2(2 * TICKS_PER_BIT + 1);

    frame_fmt_t        fmt_in;
    logic              load;
    logic              done;
    logic              is_stop;
    logic [DATA_W-1:0] data_held;
    logic [IDX_W-1:0]  last_idx;
    logic              par_en_held;
    logic              par_bit;
    logic [CNT_W-1:0]  stop_ticks;
    logic [CNT_W-1:0]  phase_limit;

    // Gather the format inputs into one record.
    always_comb begin
        fmt_in = '{len_sel: len_sel, par_en: par_en, par_even: par_even,
                   stop_long: stop_long};
    end

    // One bit time everywhere except the stop period.
    always_comb begin
        phase_limit = is_stop ? stop_ticks : CNT_W'(TICKS_PER_BIT);
    end

    txf_frame_capture #(
        .DATA_W        (DATA_W),
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .CNT_W         (CNT_W),
        .IDX_W         (IDX_W)
    ) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load),
        .busy_i       (busy),
        .data_i       (tx_data),
        .fmt_i        (fmt_in),
        .data_o       (data_held),
        .last_idx_o   (last_idx),
        .par_en_o     (par_en_held),
        .par_bit_o    (par_bit),
        .stop_ticks_o (stop_ticks)
    );

    txf_tick_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (busy),
        .tick_i  (baud_tick),
        .limit_i (phase_limit),
        .done_o  (done)
    );

    txf_phase_fsm #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (tx_start),
        .done_i     (done),
        .last_idx_i (last_idx),
        .par_en_i   (par_en_held),
        .par_bit_i  (par_bit),
        .data_i     (data_held),
        .load_o     (load),
        .busy_o     (busy),
        .is_stop_o  (is_stop),
        .txd_o      (txd)
    );

endmodule

// File: tb/sim_serial_tx_framer.sv
// Scoreboard bench: the driver task queues the expected line level for every
// baud tick of a frame; the monitor records the line at each tick while busy
// and compares the whole frame when busy falls.
module sim_serial_tx_framer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_start = 1'b0;
    logic       baud_tick = 1'b0;
    logic [1:0] len_sel = '0;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       stop_long = 1'b0;
    logic       txd;
    logic       busy;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [191:0] exp_q[$];
    int           expn_q[$];
    string        tag_q[$];

    logic [191:0] obs_v = '0;
    int           obs_n = 0;
    logic         was_busy = 1'b0;
    int           tick_div = 0;

    serial_tx_framer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_data   (tx_data),
        .tx_start  (tx_start),
        .baud_tick (baud_tick),
        .len_sel   (len_sel),
        .par_en    (par_en),
        .par_even  (par_even),
        .stop_long (stop_long),
        .txd       (txd),
        .busy      (busy)
    );

    // 50 MHz clock
    always #10 clk = ~clk;

    // Baud tick every fourth cycle, changed on the falling edge
    always @(negedge clk) begin
        tick_div <= (tick_div == 3) ? 0 : tick_div + 1;
        baud_tick <= (tick_div == 2);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: record the line at each tick while busy; compare when the frame ends
    always @(negedge clk) begin
        #2;
        if (rst_n === 1'b1) begin
            if (busy === 1'b1 && baud_tick === 1'b1) begin
                if (obs_n < 192) obs_v[obs_n] = txd;
                obs_n++;
            end
            if (was_busy && busy === 1'b0) begin
                if (exp_q.size() == 0) begin
                    check(0, "R10", "unexpected frame ticks", obs_n, 0);
                end else begin
                    logic [191:0] e;
                    int en;
                    string tg;
                    int bad;
                    e = exp_q.pop_front();
                    en = expn_q.pop_front();
                    tg = tag_q.pop_front();
                    check(obs_n == en, tg, "frame length in ticks", obs_n, en);
                    bad = -1;
                    for (int i = 0; i < en && i < 192; i++)
                        if (bad < 0 && obs_v[i] !== e[i]) bad = i;
                    check(bad < 0, tg, "first tick with wrong line level", bad, -1);
                end
                // R1: line high after every frame
                check(txd === 1'b1, "R1", "txd after frame", int'(txd), 1);
                obs_n = 0;
            end
            was_busy = (busy === 1'b1);
        end
    end

    // Driver: send one frame and queue its expected tick-by-tick line level
    task automatic send(input logic [7:0] d, input logic [1:0] ln, input logic pe,
                        input logic ev, input logic st, input logic at_tick,
                        input bit scramble, input bit hold, input string tag);
        logic [191:0] e;
        int n;
        int nb;
        int stop_n;
        logic p;
        int busy_seen;
        e = '1;
        n = 0;
        nb = 5 + int'(ln);
        p = 1'b0;
        do begin
            @(negedge clk);
            #2;
        end while (baud_tick !== at_tick);
        tx_data = d; len_sel = ln; par_en = pe; par_even = ev; stop_long = st;
        tx_start = 1'b1;
        // Expected frame: start, data LSB first, optional parity, stop
        for (int k = 0; k < 16; k++) begin e[n] = 1'b0; n++; end
        for (int b = 0; b < nb; b++) begin
            p = p ^ d[b];
            for (int k = 0; k < 16; k++) begin e[n] = d[b]; n++; end
        end
        if (pe) begin
            for (int k = 0; k < 16; k++) begin e[n] = ev ? p : ~p; n++; end
        end
        stop_n = !st ? 16 : (ln == 2'b00 ? 24 : 32);
        for (int k = 0; k < stop_n; k++) begin e[n] = 1'b1; n++; end
        exp_q.push_back(e);
        expn_q.push_back(n);
        tag_q.push_back(tag);
        @(negedge clk);
        #2;
        // R2: busy and start bit one cycle after acceptance
        check(busy === 1'b1 && txd === 1'b0, "R2", "busy/txd after accept",
              int'({busy, txd}), 2);
        tx_start = hold;
        if (scramble) begin
            // R9: new values during the frame must not reach the line
            tx_data = ~d; len_sel = ~ln; par_en = ~pe; par_even = ~ev; stop_long = ~st;
        end
        while (busy === 1'b1) begin
            @(negedge clk);
            #2;
        end
        tx_start = 1'b0;
        if (hold) begin
            // R10: strobe held through the final stop tick must not restart
            busy_seen = 0;
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                #2;
                if (busy !== 1'b0 || txd !== 1'b1) busy_seen++;
            end
            check(busy_seen == 0, "R10", "idle cycles disturbed after held strobe",
                  busy_seen, 0);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        #2;
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        // R1: reset state
        check(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
        check(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);

        // R3 R6: 8 bits, no parity, one stop
        send(8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, "R3");
        // R8: 5 bits, long stop gives 24 ticks; strobe coincides with a tick (R2)
        send(8'h3C, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 0, 0, "R8");
        // R5 R7: 6 bits, even parity, two stops
        send(8'h5A, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 0, 0, "R7");
        // R5: 7 bits, odd parity
        send(8'h5A, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 0, 0, "R5");
        // R5: all ones, even then odd
        send(8'hFF, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 0, 0, "R5");
        send(8'hFF, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0, "R5");
        // R4: parity sense ignored when parity is off
        send(8'h81, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 0, 0, "R4");
        send(8'h81, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 0, 0, "R4");
        // R7: 8 bits, two stops; R11 slow ticks already spread each bit
        send(8'hE7, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 0, 0, "R11");
        // R9: inputs scrambled mid-frame
        send(8'h96, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1, 0, "R9");
        // R10: strobe held with new data until the frame ends
        send(8'h0F, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1, 1, "R10");
        // R3: back-to-back 5-bit frame, upper bits never sent
        send(8'hE0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, "R3");

        repeat (20) @(negedge clk);
        #2;
        check(exp_q.size() == 0, "R3", "frames left unseen", exp_q.size(), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog: actual busy %0d expected frame end", int'(busy));
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule